// File: doc/BRIEF.md
# Host-Banked Shared-RAM Bridge

This block joins a PC-style host bus to the local 16-bit SRAM of a processor card. The host sees a fixed 64 KB window in its upper memory area. The window base is a parameter aligned to 64 KB, with a default of 0xD0000. An 8-bit control register on the host I/O bus supplies the bank bits above the window offset. The same register holds the processor's reset line and a window-enable bit. Many cards can have their window open at the same moment, so one host write reaches all of them. A host read is meant to address a single open card.

The card has no boot ROM. Out of reset the processor is held in reset and the host owns the RAM. The host loads a program, then clears the hold bit, and from then on the processor owns the RAM. The processor's 16 MB space is split by its top nibble. Nibble 0xF selects a 1 MB I/O region and every other value selects RAM, and both regions repeat through their ranges. A byte the processor writes into the I/O region lands in a status register, which the host polls over its I/O bus.

Top module: `shared_ram_bridge`

## Requirements
- R1: After reset the control register reads 0x80 (bank 0, window closed, hold set), the status register reads 0x00 and `cpu_reset_n` is low.
- R2: A host I/O write to `CTRL_IO_ADDR` loads the control register. Bits [BANK_BITS-1:0] are the bank, bit 6 opens the window and bit 7 holds the processor in reset. A host I/O read of that address returns the stored byte one cycle later, and `cpu_reset_n` equals the inverse of bit 7 from the cycle after the write.
- R3: With hold set and the window open, a host write inside the window goes to RAM word `{bank, host_mem_addr[15:1]}`. An even byte address writes the upper lane (`ram_be`=2'b10) and an odd address writes the lower lane (2'b01).
- R4: A granted host memory read returns the addressed lane on `host_mem_rdata` with `host_mem_rdata_oe` high one cycle after the request. Even addresses take bits [15:8] and odd addresses take bits [7:0].
- R5: While the window-enable bit is clear, host memory cycles write nothing, and `host_mem_rdata_oe` stays low.
- R6: Host memory cycles whose bits [19:16] differ from the window base are ignored.
- R7: While hold is clear, host memory cycles are ignored because the processor owns the RAM.
- R8: While hold is clear, a processor access whose address bits [23:20] are not 0xF reaches RAM word `cpu_addr[19:1]`, with byte enables {upper strobe, lower strobe}. Higher address bits are mirrored away. `cpu_dtack` rises one cycle after the strobe, and read data comes with it.
- R9: While hold is set, a processor access gets no `cpu_dtack` and writes no RAM.
- R10: A processor write anywhere in the I/O region with the lower strobe set stores `cpu_wdata[7:0]` in the status register. The host reads that byte at `STAT_IO_ADDR`, and a processor I/O read returns it on bits [7:0].
- R11: Host I/O writes to `STAT_IO_ADDR` have no effect on the status register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_mem_addr | input | 20 | Host memory byte address |
| host_mem_wr | input | 1 | Host memory write strobe |
| host_mem_rd | input | 1 | Host memory read strobe |
| host_mem_wdata | input | 8 | Host memory write byte |
| host_mem_rdata | output | 8 | Host memory read byte |
| host_mem_rdata_oe | output | 1 | Host read data valid / drive enable |
| host_io_addr | input | IO_AW | Host I/O address |
| host_io_wr | input | 1 | Host I/O write strobe |
| host_io_rd | input | 1 | Host I/O read strobe |
| host_io_wdata | input | 8 | Host I/O write byte |
| host_io_rdata | output | 8 | Host I/O read byte |
| host_io_rdata_oe | output | 1 | Host I/O read data valid |
| cpu_addr | input | 23 | Processor word address, bits [23:1] |
| cpu_as | input | 1 | Processor address strobe, active high |
| cpu_rw | input | 1 | 1 = read, 0 = write |
| cpu_uds | input | 1 | Upper byte strobe, active high |
| cpu_lds | input | 1 | Lower byte strobe, active high |
| cpu_wdata | input | 16 | Processor write data |
| cpu_rdata | output | 16 | Processor read data |
| cpu_dtack | output | 1 | Processor data acknowledge |
| cpu_reset_n | output | 1 | Processor reset, active low |
| ram_en | output | 1 | SRAM access enable |
| ram_we | output | 1 | SRAM write enable |
| ram_addr | output | 15+BANK_BITS | SRAM word address |
| ram_be | output | 2 | SRAM byte enables, [1] = upper |
| ram_wdata | output | 16 | SRAM write data |
| ram_rdata | input | 16 | SRAM read data, valid the cycle after `ram_en` |

## Verification
The SRAM drive signals follow a host or processor strobe within the same cycle, so the bench's memory model commits writes on that edge. Control-register and status reads, host memory read data and `cpu_dtack` are all registered and are due exactly one cycle after the strobe. `cpu_reset_n` follows the control write on the next cycle. Each task raises a strobe for one cycle just after a falling edge. It drops the strobe at the next falling edge and samples the outputs then, half a cycle after the edge that produced them. The bench reads RAM contents straight from its own model, and it checks cases where nothing should happen by the absence of a write or a valid flag.

// File: rtl/srb_pkg.sv
package srb_pkg;

    typedef struct packed {
        logic       hold;
        logic       win_en;
        logic [5:0] bank;
    } ctrl_t;

    localparam ctrl_t CTRL_RESET = '{hold: 1'b1, win_en: 1'b0, bank: 6'd0};

    typedef enum logic {
        CPU_RAM = 1'b0,
        CPU_IO  = 1'b1
    } cpu_region_e;

    localparam logic [3:0] IO_REGION_TAG = 4'hF;

    function automatic cpu_region_e region_of(input logic [3:0] top);
        return (top == IO_REGION_TAG) ? CPU_IO : CPU_RAM;
    endfunction

    // even host byte -> upper lane
    function automatic logic [1:0] host_lane_be(input logic a0);
        return a0 ? 2'b01 : 2'b10;
    endfunction

    function automatic logic [7:0] pick_lane(input logic [15:0] w, input logic a0);
        return a0 ? w[7:0] : w[15:8];
    endfunction

endpackage

// File: rtl/srb_host_regs.sv
module srb_host_regs
    import srb_pkg::*;
#(
    parameter int               IO_AW        = 10,
    parameter logic [IO_AW-1:0] CTRL_IO_ADDR = 10'h300,
    parameter logic [IO_AW-1:0] STAT_IO_ADDR = 10'h301
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IO_AW-1:0] io_addr,
    input  logic             io_wr,
    input  logic             io_rd,
    input  logic [7:0]       io_wdata,
    input  logic             stat_we,
    input  logic [7:0]       stat_wdata,
    output ctrl_t            ctrl,
    output logic [7:0]       status,
    output logic [7:0]       io_rdata,
    output logic             io_rdata_oe
);

    logic hit_ctrl;
    logic hit_stat;

    assign hit_ctrl = (io_addr == CTRL_IO_ADDR);
    assign hit_stat = (io_addr == STAT_IO_ADDR);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl        <= CTRL_RESET;
            status      <= 8'h00;
            io_rdata    <= 8'h00;
            io_rdata_oe <= 1'b0;
        end else begin
            if (io_wr && hit_ctrl)
                ctrl <= ctrl_t'(io_wdata);
            if (stat_we)
                status <= stat_wdata;
            io_rdata_oe <= 1'b0;
            if (io_rd && hit_ctrl) begin
                io_rdata    <= ctrl;
                io_rdata_oe <= 1'b1;
            end else if (io_rd && hit_stat) begin
                io_rdata    <= status;
                io_rdata_oe <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/srb_cpu_decode.sv
module srb_cpu_decode
    import srb_pkg::*;
#(
    parameter int RAW = 19
) (
    input  logic [23:1]    cpu_addr,
    input  logic           cpu_as,
    input  logic           cpu_rw,
    input  logic           cpu_uds,
    input  logic           cpu_lds,
    input  logic [15:0]    cpu_wdata,
    input  logic           grant,
    output logic           ram_req,
    output logic           ram_wr,
    output logic [RAW-1:0] ram_word,
    output logic [1:0]     ram_be,
    output logic           io_acc,
    output logic           stat_we,
    output logic [7:0]     stat_wdata
);

    cpu_region_e region;
    logic        live;

    assign region     = region_of(cpu_addr[23:20]);
    assign live       = cpu_as && grant;
    assign ram_req    = live && (region == CPU_RAM);
    assign ram_wr     = ram_req && !cpu_rw;
    assign ram_word   = cpu_addr[RAW:1];
    assign ram_be     = {cpu_uds, cpu_lds};
    assign io_acc     = live && (region == CPU_IO);
    assign stat_we    = io_acc && !cpu_rw && cpu_lds;
    assign stat_wdata = cpu_wdata[7:0];

endmodule

// File: rtl/srb_ram_arb.sv
module srb_ram_arb
    import srb_pkg::*;
#(
    parameter int          BANK_BITS = 4,
    parameter int          RAW       = 15 + BANK_BITS,
    parameter logic [19:0] WIN_BASE  = 20'hD0000
) (
    input  logic           clk,
    input  logic           rst,
    input  ctrl_t          ctrl,
    input  logic [7:0]     status,
    input  logic [19:0]    host_addr,
    input  logic           host_wr,
    input  logic           host_rd,
    input  logic [7:0]     host_wdata,
    output logic [7:0]     host_rdata,
    output logic           host_rdata_oe,
    input  logic           cpu_ram_req,
    input  logic           cpu_ram_wr,
    input  logic [RAW-1:0] cpu_word,
    input  logic [1:0]     cpu_be,
    input  logic [15:0]    cpu_wdata,
    input  logic           cpu_io_acc,
    output logic [15:0]    cpu_rdata,
    output logic           cpu_dtack,
    output logic           ram_en,
    output logic           ram_we,
    output logic [RAW-1:0] ram_addr,
    output logic [1:0]     ram_be,
    output logic [15:0]    ram_wdata,
    input  logic [15:0]    ram_rdata
);

    logic host_go;
    logic hrd_q;
    logic lane_q;
    logic ack_q;
    logic io_q;

    assign host_go = (host_addr[19:16] == WIN_BASE[19:16]) && ctrl.win_en && ctrl.hold;

    always_comb begin
        if (ctrl.hold) begin
            ram_en    = host_go && (host_wr || host_rd);
            ram_we    = host_go && host_wr;
            ram_addr  = {ctrl.bank[BANK_BITS-1:0], host_addr[15:1]};
            ram_be    = host_lane_be(host_addr[0]);
            ram_wdata = {host_wdata, host_wdata};
        end else begin
            ram_en    = cpu_ram_req;
            ram_we    = cpu_ram_wr;
            ram_addr  = cpu_word;
            ram_be    = cpu_be;
            ram_wdata = cpu_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hrd_q  <= 1'b0;
            lane_q <= 1'b0;
            ack_q  <= 1'b0;
            io_q   <= 1'b0;
        end else begin
            hrd_q  <= host_go && host_rd && !host_wr;
            lane_q <= host_addr[0];
            ack_q  <= cpu_ram_req || cpu_io_acc;
            io_q   <= cpu_io_acc;
        end
    end

    assign host_rdata_oe = hrd_q;
    assign host_rdata    = hrd_q ? pick_lane(ram_rdata, lane_q) : 8'h00;
    assign cpu_dtack     = ack_q;
    assign cpu_rdata     = io_q  ? {8'h00, status} :
                           ack_q ? ram_rdata : 16'h0000;

endmodule

// File: rtl/shared_ram_bridge.sv
module shared_ram_bridge
    import srb_pkg::*;
#(
    parameter int               BANK_BITS    = 4,
    parameter logic [19:0]      WIN_BASE     = 20'hD0000,
    parameter int               IO_AW        = 10,
    parameter logic [IO_AW-1:0] CTRL_IO_ADDR = 10'h300,
    parameter logic [IO_AW-1:0] STAT_IO_ADDR = 10'h301,
    localparam int              RAW          = 15 + BANK_BITS
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [19:0]      host_mem_addr,
    input  logic             host_mem_wr,
    input  logic             host_mem_rd,
    input  logic [7:0]       host_mem_wdata,
    output logic [7:0]       host_mem_rdata,
    output logic             host_mem_rdata_oe,
    input  logic [IO_AW-1:0] host_io_addr,
    input  logic             host_io_wr,
    input  logic             host_io_rd,
    input  logic [7:0]       host_io_wdata,
    output logic [7:0]       host_io_rdata,
    output logic             host_io_rdata_oe,
    input  logic [23:1]      cpu_addr,
    input  logic             cpu_as,
    input  logic             cpu_rw,
    input  logic             cpu_uds,
    input  logic             cpu_lds,
    input  logic [15:0]      cpu_wdata,
    output logic [15:0]      cpu_rdata,
    output logic             cpu_dtack,
    output logic             cpu_reset_n,
    output logic             ram_en,
    output logic             ram_we,
    output logic [RAW-1:0]   ram_addr,
    output logic [1:0]       ram_be,
    output logic [15:0]      ram_wdata,
    input  logic [15:0]      ram_rdata
);

    ctrl_t          ctrl_q;
    logic [7:0]     status_q;
    logic           stat_we;
    logic [7:0]     stat_wdata;
    logic           c_ram_req;
    logic           c_ram_wr;
    logic [RAW-1:0] c_word;
    logic [1:0]     c_be;
    logic           c_io_acc;

    assign cpu_reset_n = !ctrl_q.hold;

    srb_host_regs #(
        .IO_AW(IO_AW), .CTRL_IO_ADDR(CTRL_IO_ADDR), .STAT_IO_ADDR(STAT_IO_ADDR)
    ) u_regs (
        .clk(clk), .rst(rst),
        .io_addr(host_io_addr), .io_wr(host_io_wr), .io_rd(host_io_rd),
        .io_wdata(host_io_wdata), .stat_we(stat_we), .stat_wdata(stat_wdata),
        .ctrl(ctrl_q), .status(status_q),
        .io_rdata(host_io_rdata), .io_rdata_oe(host_io_rdata_oe)
    );

    srb_cpu_decode #(.RAW(RAW)) u_dec (
        .cpu_addr(cpu_addr), .cpu_as(cpu_as), .cpu_rw(cpu_rw),
        .cpu_uds(cpu_uds), .cpu_lds(cpu_lds), .cpu_wdata(cpu_wdata),
        .grant(!ctrl_q.hold),
        .ram_req(c_ram_req), .ram_wr(c_ram_wr), .ram_word(c_word), .ram_be(c_be),
        .io_acc(c_io_acc), .stat_we(stat_we), .stat_wdata(stat_wdata)
    );

    srb_ram_arb #(.BANK_BITS(BANK_BITS), .RAW(RAW), .WIN_BASE(WIN_BASE)) u_arb (
        .clk(clk), .rst(rst), .ctrl(ctrl_q), .status(status_q),
        .host_addr(host_mem_addr), .host_wr(host_mem_wr), .host_rd(host_mem_rd),
        .host_wdata(host_mem_wdata), .host_rdata(host_mem_rdata),
        .host_rdata_oe(host_mem_rdata_oe),
        .cpu_ram_req(c_ram_req), .cpu_ram_wr(c_ram_wr), .cpu_word(c_word),
        .cpu_be(c_be), .cpu_wdata(cpu_wdata), .cpu_io_acc(c_io_acc),
        .cpu_rdata(cpu_rdata), .cpu_dtack(cpu_dtack),
        .ram_en(ram_en), .ram_we(ram_we), .ram_addr(ram_addr), .ram_be(ram_be),
        .ram_wdata(ram_wdata), .ram_rdata(ram_rdata)
    );

endmodule

// File: rtl/srb_chk.sv
module srb_chk (
    input logic       clk,
    input logic       rst,
    input logic       cpu_reset_n,
    input logic       cpu_dtack,
    input logic       cpu_as,
    input logic       cpu_rw,
    input logic       host_mem_rd,
    input logic       host_mem_wr,
    input logic       host_mem_rdata_oe,
    input logic       ram_en,
    input logic [7:0] status_q
);

    // R1
    reset_hold_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !cpu_reset_n);

    // R9
    dtack_needs_run_chk: assert property (@(posedge clk) disable iff (rst)
        cpu_dtack |-> $past(cpu_reset_n && cpu_as));

    // R4
    host_rdata_timing_chk: assert property (@(posedge clk) disable iff (rst)
        host_mem_rdata_oe |-> $past(host_mem_rd));

    // R7
    host_owner_chk: assert property (@(posedge clk) disable iff (rst)
        (ram_en && !cpu_reset_n) |-> (host_mem_wr || host_mem_rd));

    // R8
    cpu_owner_chk: assert property (@(posedge clk) disable iff (rst)
        (ram_en && cpu_reset_n) |-> cpu_as);

    // R11
    status_stable_chk: assert property (@(posedge clk) disable iff (rst)
        !(cpu_as && !cpu_rw) |=> $stable(status_q));

endmodule

bind shared_ram_bridge srb_chk u_chk (
    .clk(clk), .rst(rst), .cpu_reset_n(cpu_reset_n), .cpu_dtack(cpu_dtack),
    .cpu_as(cpu_as), .cpu_rw(cpu_rw), .host_mem_rd(host_mem_rd),
    .host_mem_wr(host_mem_wr), .host_mem_rdata_oe(host_mem_rdata_oe),
    .ram_en(ram_en), .status_q(status_q)
);

// File: tb/tb_shared_ram_bridge.sv
module tb_shared_ram_bridge;

    localparam logic [9:0] CTRL_A = 10'h300;
    localparam logic [9:0] STAT_A = 10'h301;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [19:0] host_mem_addr = '0;
    logic        host_mem_wr = 1'b0, host_mem_rd = 1'b0;
    logic [7:0]  host_mem_wdata = '0;
    logic [7:0]  host_mem_rdata;
    logic        host_mem_rdata_oe;
    logic [9:0]  host_io_addr = '0;
    logic        host_io_wr = 1'b0, host_io_rd = 1'b0;
    logic [7:0]  host_io_wdata = '0;
    logic [7:0]  host_io_rdata;
    logic        host_io_rdata_oe;
    logic [23:1] cpu_addr = '0;
    logic        cpu_as = 1'b0, cpu_rw = 1'b1, cpu_uds = 1'b0, cpu_lds = 1'b0;
    logic [15:0] cpu_wdata = '0;
    logic [15:0] cpu_rdata;
    logic        cpu_dtack, cpu_reset_n;
    logic        ram_en, ram_we;
    logic [18:0] ram_addr;
    logic [1:0]  ram_be;
    logic [15:0] ram_wdata;
    logic [15:0] ram_rdata = '0;

    int n_chk = 0;
    int n_bad = 0;

    logic [15:0] mem [int unsigned];

    always #10 clk = ~clk;

    shared_ram_bridge dut (.*);

    function automatic logic [15:0] peek(input int unsigned a);
        return mem.exists(a) ? mem[a] : 16'h0000;
    endfunction

    always @(posedge clk) begin
        if (ram_en) begin
            logic [15:0] w;
            w = peek(ram_addr);
            if (ram_we) begin
                if (ram_be[1]) w[15:8] = ram_wdata[15:8];
                if (ram_be[0]) w[7:0]  = ram_wdata[7:0];
                mem[ram_addr] = w;
            end
            ram_rdata <= w;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic io_write(input logic [9:0] a, input logic [7:0] d);
        @(negedge clk); host_io_addr = a; host_io_wdata = d; host_io_wr = 1'b1;
        @(negedge clk); host_io_wr = 1'b0;
    endtask

    task automatic io_read(input logic [9:0] a, output logic [7:0] d, output logic oe);
        @(negedge clk); host_io_addr = a; host_io_rd = 1'b1;
        @(negedge clk); host_io_rd = 1'b0; d = host_io_rdata; oe = host_io_rdata_oe;
    endtask

    task automatic mem_write(input logic [19:0] a, input logic [7:0] d);
        @(negedge clk); host_mem_addr = a; host_mem_wdata = d; host_mem_wr = 1'b1;
        @(negedge clk); host_mem_wr = 1'b0;
    endtask

    task automatic mem_read(input logic [19:0] a, output logic [7:0] d, output logic oe);
        @(negedge clk); host_mem_addr = a; host_mem_rd = 1'b1;
        @(negedge clk); host_mem_rd = 1'b0; d = host_mem_rdata; oe = host_mem_rdata_oe;
    endtask

    task automatic cpu_cycle(input logic [23:0] a, input logic rw, input logic u, input logic l,
                             input logic [15:0] wd, output logic [15:0] rd, output logic ack);
        @(negedge clk); cpu_addr = a[23:1]; cpu_rw = rw; cpu_uds = u; cpu_lds = l;
        cpu_wdata = wd; cpu_as = 1'b1;
        @(negedge clk); cpu_as = 1'b0; cpu_rw = 1'b1; rd = cpu_rdata; ack = cpu_dtack;
    endtask

    task automatic t_reset();
        logic [7:0] d; logic oe;
        check("R1 cpu_reset_n", cpu_reset_n, 0);
        io_read(CTRL_A, d, oe);
        check("R1 ctrl", {oe, d}, 9'h180);
        io_read(STAT_A, d, oe);
        check("R1 status", {oe, d}, 9'h100);
    endtask

    task automatic t_ctrl();
        logic [7:0] d; logic oe;
        io_write(CTRL_A, 8'h43);
        check("R2 release", cpu_reset_n, 1);
        io_write(CTRL_A, 8'hC3);
        check("R2 hold", cpu_reset_n, 0);
        io_read(CTRL_A, d, oe);
        check("R2 readback", {oe, d}, 9'h1C3);
    endtask

    task automatic t_host_rw();
        logic [7:0] d; logic oe;
        mem_write(20'hD0010, 8'hA5);
        mem_write(20'hD0011, 8'h5A);
        check("R3 lanes bank3", peek(32'h18008), 16'hA55A);
        mem_read(20'hD0011, d, oe);
        check("R4 odd lane", {oe, d}, 9'h15A);
        mem_read(20'hD0010, d, oe);
        check("R4 even lane", {oe, d}, 9'h1A5);
        io_write(CTRL_A, 8'hC5);
        mem_write(20'hD0010, 8'h11);
        check("R3 bank5", peek(32'h28008), 16'h1100);
        check("R3 bank3 kept", peek(32'h18008), 16'hA55A);
    endtask

    task automatic t_window();
        logic [7:0] d; logic oe;
        io_write(CTRL_A, 8'h83);
        mem_write(20'hD0010, 8'hEE);
        mem_read(20'hD0010, d, oe);
        check("R5 closed oe", oe, 0);
        io_write(CTRL_A, 8'hC3);
        mem_write(20'hC0010, 8'h77);
        mem_read(20'hC0010, d, oe);
        check("R6 outside oe", oe, 0);
        check("R5 R6 no write", peek(32'h18008), 16'hA55A);
    endtask

    task automatic t_cpu();
        logic [15:0] r; logic ack; logic [7:0] d; logic oe;
        io_write(CTRL_A, 8'h43);
        cpu_cycle(24'h030020, 1'b0, 1'b1, 1'b1, 16'hBEEF, r, ack);
        check("R8 write ack", ack, 1);
        check("R8 write ram", peek(32'h18010), 16'hBEEF);
        cpu_cycle(24'h330020, 1'b1, 1'b1, 1'b1, 16'h0, r, ack);
        check("R8 mirror read", {ack, r}, 17'h1BEEF);
        cpu_cycle(24'h030020, 1'b0, 1'b0, 1'b1, 16'h7712, r, ack);
        check("R8 lower lane", peek(32'h18010), 16'hBE12);
        mem_write(20'hD0010, 8'h33);
        check("R7 host write ignored", peek(32'h18008), 16'hA55A);
        mem_read(20'hD0010, d, oe);
        check("R7 host read oe", oe, 0);
        cpu_cycle(24'hF00002, 1'b0, 1'b0, 1'b1, 16'h0042, r, ack);
        check("R10 io ack", ack, 1);
        io_read(STAT_A, d, oe);
        check("R10 status host", {oe, d}, 9'h142);
        cpu_cycle(24'hFABCDE, 1'b1, 1'b1, 1'b1, 16'h0, r, ack);
        check("R10 io mirror read", {ack, r}, 17'h10042);
        io_write(STAT_A, 8'h99);
        io_read(STAT_A, d, oe);
        check("R11 status read-only", {oe, d}, 9'h142);
    endtask

    task automatic t_held();
        logic [15:0] r; logic ack;
        io_write(CTRL_A, 8'hC3);
        cpu_cycle(24'h030020, 1'b0, 1'b1, 1'b1, 16'h1111, r, ack);
        check("R9 no dtack", ack, 0);
        check("R9 no write", peek(32'h18010), 16'hBE12);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_ctrl();
        t_host_rw();
        t_window();
        t_cpu();
        t_held();
        repeat (2) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule